// File: doc/BRIEF.md
# Packet Fetch and Decode Front End

This block is the instruction front end of a wide-issue processor that fetches a whole packet of instruction slots every clock. An address generator steps through program memory one packet at a time. Each packet address goes out to a synchronous program memory with a fixed read latency. The returned packet then moves through a dispatch stage and a decode stage, and leaves as a row of instruction slots, each with its own valid and branch flags. In steady state one packet enters the pipe and one packet leaves it on every clock.

The fetch side has four stages: generate, send, wait and read. The wait stage covers the two-cycle memory latency. A redirect from the execute side loads a new packet-aligned address and discards every packet still in those four fetch stages. Packets already in dispatch or decode carry on and become the delay slots of the branch. The block has no interlocks of any kind, so the code it runs must be scheduled to avoid hazards.

An interrupt request is granted only when no branch is in flight. A branch counts as in flight from the moment its packet is read from memory, through dispatch and decode, and for a fixed execute window after it leaves decode.

Top module: `fe_frontend`

## Requirements
- R1: While reset is held, `memReq`, `decValid`, `irqAck`, `decSlotValid` and `decBranch` are all low. The first address sent after reset is `RESET_ADDR` (default 0).
- R2: When no redirect occurs, `memReq` is high on every cycle after the first, and `memAddr` rises by 32 bytes (one packet of eight 32-bit words) from one cycle to the next.
- R3: The memory returns the packet for an address sent in cycle c during cycle c+2. The same packet appears on the decode outputs in cycle c+4, with `decValid` high, `decPc` equal to the packet address, and slot i on `decInstr[32*i +: 32]`.
- R4: A slot whose word is all zero is a no-op and has `decSlotValid[i]` low. Any nonzero word gives a valid slot.
- R5: `decBranch[i]` is high exactly when slot i is valid and bits [31:26] of its word equal 6'b101010.
- R6: A redirect in cycle c causes the following:
  - `memReq` is low in cycle c+1.
  - The target, with its low five bits cleared, is sent in cycle c+2.
  - No packet that was in a fetch stage during cycle c ever reaches the decode outputs.
  - Packets in dispatch or decode during cycle c still come out.
- R7: In any cycle in which `irqReq` is high and no branch packet is in the read, dispatch or decode stage or in the execute window, `irqAck` is high. In every other cycle `irqAck` is low. The requester holds `irqReq` until it sees `irqAck`.
- R8: For the 5 cycles (`EXEC_DEPTH`) after a packet containing a branch leaves the decode stage, `irqAck` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| memReq | output | 1 | Packet address valid towards program memory |
| memAddr | output | 32 | Packet-aligned byte address sent to memory |
| memData | input | 256 | Packet returned by memory, two cycles after the address |
| redirectValid | input | 1 | Branch redirect from execute |
| redirectTarget | input | 32 | Redirect byte address; the low five bits are ignored |
| irqReq | input | 1 | Interrupt request, held until acknowledged |
| irqAck | output | 1 | Interrupt accepted in this cycle |
| decValid | output | 1 | A decoded packet is present |
| decPc | output | 32 | Address of the decoded packet |
| decInstr | output | 256 | Decoded packet, slot i at bits 32*i +: 32 |
| decSlotValid | output | 8 | Per-slot valid (nonzero word) |
| decBranch | output | 8 | Per-slot branch flag |

## Verification
The per-cycle timing fixes when each result must appear:
- An address must show on `memAddr` one cycle after it is generated.
- The matching packet must reach the decode outputs four cycles after that address was sent.
- A redirect must blank `memReq` for one cycle and put its target out one cycle later.
- `irqAck` is combinational in the same cycle as the branch-tracking state, and after a branch packet leaves decode the acknowledge stays low for exactly `EXEC_DEPTH` cycles.

The bench keeps a queue of packet addresses tagged with their stage numbers and advances it on each rising edge, applying redirects to it. It compares every output on the falling edge, so each expected value is taken in the cycle in which the register chain delivers it.

// File: rtl/fe_pkg.sv
package fe_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic redirect;  // load a new fetch address, drop the fetch stages
    logic frTake;    // the packet in the read stage moves into dispatch
    logic dpTake;    // the packet in dispatch moves into decode
  } feStrobes_t;

endpackage

// File: rtl/fe_slot_predecode.sv
module fe_slot_predecode #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned OPC_LSB = 26,
  parameter int unsigned OPC_W   = 6,
  parameter logic [OPC_W-1:0] BR_OPC = 6'h2A
) (
  input  logic [INSTR_W-1:0] word,
  output logic               live,
  output logic               isBranch
);

  // An all-zero word is a no-op; every other word occupies its slot.
  assign live     = |word;
  assign isBranch = live && (word[OPC_LSB +: OPC_W] == BR_OPC);

endmodule

// File: rtl/fe_datapath.sv
module fe_datapath
  import fe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SLOTS      = 8,
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned OPC_LSB    = 26,
  parameter int unsigned OPC_W      = 6,
  parameter logic [OPC_W-1:0]  BR_OPC     = 6'h2A,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  feStrobes_t                 strobes,
  input  logic [ADDR_W-1:0]          redirTarget,
  output logic [ADDR_W-1:0]          memAddr,
  input  logic [SLOTS*INSTR_W-1:0]   memData,
  output logic                       frHasBr,
  output logic                       dpHasBr,
  output logic                       dcHasBr,
  output logic [ADDR_W-1:0]          decPc,
  output logic [SLOTS*INSTR_W-1:0]   decInstr,
  output logic [SLOTS-1:0]           decSlotValid,
  output logic [SLOTS-1:0]           decBranch
);

  localparam int unsigned PKT_BYTES = SLOTS * INSTR_W / 8;
  localparam int unsigned OFF_W     = $clog2(PKT_BYTES);
  localparam int unsigned PKT_W     = SLOTS * INSTR_W;

  function automatic logic [ADDR_W-1:0] alignPkt(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // fetch stage addresses: generate, send, wait, read
  logic [ADDR_W-1:0] fgPc, fsPc, fwPc, frPc;
  // dispatch and decode stage contents
  logic [ADDR_W-1:0] dpPc, dcPc;
  logic [PKT_W-1:0]  dpWords, dcWords;
  logic [SLOTS-1:0]  frLive, frBr, dpLive, dpBr, dcLive, dcBr;

  // pre-decode each slot of the packet arriving in the read stage
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    fe_slot_predecode #(
      .INSTR_W (INSTR_W),
      .OPC_LSB (OPC_LSB),
      .OPC_W   (OPC_W),
      .BR_OPC  (BR_OPC)
    ) uPre (
      .word     (memData[g*INSTR_W +: INSTR_W]),
      .live     (frLive[g]),
      .isBranch (frBr[g])
    );
  end

  // fetch address chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fgPc <= alignPkt(RESET_ADDR);
      fsPc <= '0;
      fwPc <= '0;
      frPc <= '0;
    end else begin
      fgPc <= strobes.redirect ? alignPkt(redirTarget)
                               : fgPc + ADDR_W'(PKT_BYTES);
      fsPc <= fgPc;
      fwPc <= fsPc;
      frPc <= fwPc;
    end
  end

  // read -> dispatch capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dpPc    <= '0;
      dpWords <= '0;
      dpLive  <= '0;
      dpBr    <= '0;
    end else if (strobes.frTake) begin
      dpPc    <= frPc;
      dpWords <= memData;
      dpLive  <= frLive;
      dpBr    <= frBr;
    end
  end

  // dispatch -> decode: slot flags only survive with a live packet
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dcPc    <= '0;
      dcWords <= '0;
      dcLive  <= '0;
      dcBr    <= '0;
    end else if (strobes.dpTake) begin
      dcPc    <= dpPc;
      dcWords <= dpWords;
      dcLive  <= dpLive;
      dcBr    <= dpBr & dpLive;
    end else begin
      dcLive  <= '0;
      dcBr    <= '0;
    end
  end

  assign memAddr      = fsPc;
  assign frHasBr      = |frBr;
  assign dpHasBr      = |dpBr;
  assign dcHasBr      = |dcBr;
  assign decPc        = dcPc;
  assign decInstr     = dcWords;
  assign decSlotValid = dcLive;
  assign decBranch    = dcBr;

  // The redirect target reaches the memory address two cycles on.
  assert_redirect_target_R6 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.redirect |-> ##2 (memAddr[ADDR_W-1:OFF_W] == $past(redirTarget[ADDR_W-1:OFF_W], 2)));

  // A valid decode slot never carries a no-op word.
  for (genvar g = 0; g < SLOTS; g++) begin : gChk
    assert_live_slot_R4 : assert property (@(posedge clk) disable iff (!rstN)
      decSlotValid[g] |-> (decInstr[g*INSTR_W +: INSTR_W] != '0));
  end

endmodule

// File: rtl/fe_control.sv
module fe_control
  import fe_pkg::*;
#(
  parameter int unsigned EXEC_DEPTH = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       redirectReq,
  input  logic       irqReq,
  input  logic       frHasBr,
  input  logic       dpHasBr,
  input  logic       dcHasBr,
  output feStrobes_t strobes,
  output logic       memReq,
  output logic       decValid,
  output logic       irqAck
);

  localparam int unsigned CNT_W = $clog2(EXEC_DEPTH + 1);

  logic fsValid, fwValid, frValid, dpValid, dcValid;
  logic [CNT_W-1:0] execCnt;
  logic branchInFlight;

  assign strobes.redirect = redirectReq;
  assign strobes.frTake   = frValid && !redirectReq;
  assign strobes.dpTake   = dpValid;

  // valid chain; a redirect drops everything in the fetch stages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsValid <= 1'b0;
      fwValid <= 1'b0;
      frValid <= 1'b0;
      dpValid <= 1'b0;
      dcValid <= 1'b0;
    end else begin
      fsValid <= !redirectReq;
      fwValid <= fsValid && !redirectReq;
      frValid <= fwValid && !redirectReq;
      dpValid <= frValid && !redirectReq;
      dcValid <= dpValid;
    end
  end

  // execute window that follows a branch packet out of decode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      execCnt <= '0;
    end else if (dcValid && dcHasBr) begin
      execCnt <= CNT_W'(EXEC_DEPTH);
    end else if (execCnt != '0) begin
      execCnt <= execCnt - 1'b1;
    end
  end

  assign branchInFlight = (frValid && frHasBr) || (dpValid && dpHasBr) ||
                          (dcValid && dcHasBr) || (execCnt != '0);

  assign irqAck   = irqReq && !branchInFlight;
  assign memReq   = fsValid;
  assign decValid = dcValid;

  assert_steady_issue_R2 : assert property (@(posedge clk) disable iff (!rstN)
    !redirectReq |=> memReq);

  assert_redirect_flush_R6 : assert property (@(posedge clk) disable iff (!rstN)
    redirectReq |=> !memReq);

  assert_ack_needs_req_R7 : assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> irqReq);

  assert_dispatch_branch_blocks_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (dpValid && dpHasBr) |=> !irqAck);

  assert_exec_window_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (dcValid && dcHasBr) |=> !irqAck);

endmodule

// File: rtl/fe_frontend.sv
module fe_frontend
  import fe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SLOTS      = 8,
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned EXEC_DEPTH = 5,
  parameter int unsigned OPC_LSB    = 26,
  parameter int unsigned OPC_W      = 6,
  parameter logic [OPC_W-1:0]  BR_OPC     = 6'h2A,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  output logic                     memReq,
  output logic [ADDR_W-1:0]        memAddr,
  input  logic [SLOTS*INSTR_W-1:0] memData,
  input  logic                     redirectValid,
  input  logic [ADDR_W-1:0]        redirectTarget,
  input  logic                     irqReq,
  output logic                     irqAck,
  output logic                     decValid,
  output logic [ADDR_W-1:0]        decPc,
  output logic [SLOTS*INSTR_W-1:0] decInstr,
  output logic [SLOTS-1:0]         decSlotValid,
  output logic [SLOTS-1:0]         decBranch
);

  feStrobes_t strobes;
  logic frHasBr, dpHasBr, dcHasBr;

  fe_control #(
    .EXEC_DEPTH (EXEC_DEPTH)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .redirectReq (redirectValid),
    .irqReq      (irqReq),
    .frHasBr     (frHasBr),
    .dpHasBr     (dpHasBr),
    .dcHasBr     (dcHasBr),
    .strobes     (strobes),
    .memReq      (memReq),
    .decValid    (decValid),
    .irqAck      (irqAck)
  );

  fe_datapath #(
    .ADDR_W     (ADDR_W),
    .SLOTS      (SLOTS),
    .INSTR_W    (INSTR_W),
    .OPC_LSB    (OPC_LSB),
    .OPC_W      (OPC_W),
    .BR_OPC     (BR_OPC),
    .RESET_ADDR (RESET_ADDR)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .redirTarget  (redirectTarget),
    .memAddr      (memAddr),
    .memData      (memData),
    .frHasBr      (frHasBr),
    .dpHasBr      (dpHasBr),
    .dcHasBr      (dcHasBr),
    .decPc        (decPc),
    .decInstr     (decInstr),
    .decSlotValid (decSlotValid),
    .decBranch    (decBranch)
  );

endmodule

// File: tb/tb_fe_frontend.sv
module tb_fe_frontend;

  localparam int SLOTS    = 8;
  localparam int EXEC_DEP = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rstN;
  logic         memReq;
  logic [31:0]  memAddr;
  logic [255:0] memData;
  logic         redirectValid;
  logic [31:0]  redirectTarget;
  logic         irqReq;
  logic         irqAck;
  logic         decValid;
  logic [31:0]  decPc;
  logic [255:0] decInstr;
  logic [7:0]   decSlotValid;
  logic [7:0]   decBranch;

  fe_frontend dut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .redirectValid(redirectValid), .redirectTarget(redirectTarget),
    .irqReq(irqReq), .irqAck(irqAck), .decValid(decValid), .decPc(decPc),
    .decInstr(decInstr), .decSlotValid(decSlotValid), .decBranch(decBranch)
  );

  int vectors = 0;
  int miscompares = 0;
  int accepted = 0;
  int blockedSeen = 0;
  bit finished = 0;

  // program memory contents, branches only inside 0x1000..0x10FF
  function automatic logic [31:0] memWord(logic [31:0] addr, int slot);
    int unsigned key;
    key = (addr >> 5) * 8 + slot;
    if (key % 5 == 2) return 32'h0;
    if (addr >= 32'h1000 && addr < 32'h1100 && key % 7 == 1) return {6'h2A, 26'(key)};
    return {6'h01, 26'(key * 32'h9E3779B1 + 1)};
  endfunction

  function automatic logic [255:0] pktData(logic [31:0] addr);
    logic [255:0] d;
    for (int i = 0; i < SLOTS; i++) d[i*32 +: 32] = memWord(addr, i);
    return d;
  endfunction

  function automatic logic [7:0] pktLive(logic [31:0] addr);
    logic [7:0] v;
    for (int i = 0; i < SLOTS; i++) v[i] = (memWord(addr, i) != 0);
    return v;
  endfunction

  function automatic logic [7:0] pktBr(logic [31:0] addr);
    logic [7:0] v;
    logic [31:0] w;
    for (int i = 0; i < SLOTS; i++) begin
      w = memWord(addr, i);
      v[i] = (w != 0) && (w[31:26] == 6'b101010);
    end
    return v;
  endfunction

  // synchronous memory, two cycles from address to data
  logic        memStageV;
  logic [31:0] memStage;
  always @(posedge clk) begin
    memStageV <= memReq;
    memStage  <= memAddr;
    memData   <= memStageV ? pktData(memStage) : '0;
  end

  // reference model: packet addresses tagged with stage 1..5
  // (1 send, 2 wait, 3 read, 4 dispatch, 5 decode)
  typedef struct { logic [31:0] addr; int stage; } ent_t;
  ent_t q[$];
  logic [31:0] genAddr;
  int shadow;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      genAddr = 32'h0;
      shadow  = 0;
    end else begin
      bit brOut;
      brOut = 0;
      foreach (q[i]) if (q[i].stage == 5 && pktBr(q[i].addr) != 0) brOut = 1;
      if (redirectValid)
        for (int i = q.size() - 1; i >= 0; i--) if (q[i].stage <= 3) q.delete(i);
      for (int i = q.size() - 1; i >= 0; i--) begin
        q[i].stage++;
        if (q[i].stage > 5) q.delete(i);
      end
      if (redirectValid) genAddr = {redirectTarget[31:5], 5'b0};
      else begin
        q.push_back('{addr: genAddr, stage: 1});
        genAddr = genAddr + 32;
      end
      if (brOut) shadow = EXEC_DEP;
      else if (shadow > 0) shadow--;
    end
  end

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit eReq, eDec, inFlight;
    logic [31:0] eAddr, ePc;
    eReq = 0; eDec = 0; inFlight = (shadow > 0);
    eAddr = '0; ePc = '0;
    foreach (q[i]) begin
      if (q[i].stage == 1) begin eReq = 1; eAddr = q[i].addr; end
      if (q[i].stage == 5) begin eDec = 1; ePc = q[i].addr; end
      if (q[i].stage >= 3 && pktBr(q[i].addr) != 0) inFlight = 1;
    end
    vectors++;
    chk("R2/R6", "memReq", 256'(memReq), 256'(eReq));
    if (eReq) chk("R2/R6", "memAddr", 256'(memAddr), 256'(eAddr));
    chk("R3/R6", "decValid", 256'(decValid), 256'(eDec));
    if (eDec) begin
      chk("R3", "decPc", 256'(decPc), 256'(ePc));
      chk("R3", "decInstr", decInstr, pktData(ePc));
      chk("R4", "decSlotValid", 256'(decSlotValid), 256'(pktLive(ePc)));
      chk("R5", "decBranch", 256'(decBranch), 256'(pktBr(ePc)));
    end else begin
      chk("R4", "decSlotValid idle", 256'(decSlotValid), 256'(0));
      chk("R5", "decBranch idle", 256'(decBranch), 256'(0));
    end
    if (irqReq && inFlight) blockedSeen++;
    chk("R7/R8", "irqAck", 256'(irqAck), 256'(irqReq && !inFlight));
  endtask

  // one clock: inputs set before the call are taken at the rising edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    if (irqReq && irqAck) begin
      accepted++;
      irqReq = 1'b0;
    end
  endtask

  task automatic redirect(logic [31:0] t);
    redirectValid  = 1'b1;
    redirectTarget = t;
    cyc();
    redirectValid  = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; redirectValid = 1'b0; redirectTarget = '0; irqReq = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    vectors++;
    chk("R1", "memReq in reset", 256'(memReq), 256'(0));
    chk("R1", "decValid in reset", 256'(decValid), 256'(0));
    chk("R1", "irqAck in reset", 256'(irqAck), 256'(0));
    chk("R1", "decSlotValid in reset", 256'(decSlotValid), 256'(0));
    chk("R1", "decBranch in reset", 256'(decBranch), 256'(0));
    compareAll();
    rstN = 1'b1;
    // R2, R3: sequential stream from the reset address, interrupt granted
    for (int i = 0; i < 20; i++) begin
      if (i == 6) irqReq = 1'b1;
      cyc();
    end
    // R6: unaligned redirect into the branch region, R7/R8 blocking
    redirect(32'h0000_1234);
    for (int i = 0; i < 40; i++) begin
      if (i == 4) irqReq = 1'b1;
      cyc();
    end
    // R6: back-to-back redirects, only the last survives
    redirect(32'h0000_3000);
    redirect(32'h0000_3047);
    redirect(32'h0000_0FC0);
    for (int i = 0; i < 30; i++) begin
      if (i == 2) irqReq = 1'b1;
      cyc();
    end
    // redirect while branch packets sit in dispatch/decode
    redirect(32'h0000_1000);
    repeat (5) cyc();
    redirect(32'h0000_4000);
    irqReq = 1'b1;
    repeat (25) cyc();
    // mixed pattern of redirects and requests
    for (int k = 0; k < 12; k++) begin
      redirect(32'h0000_1000 + k * 32'h68);
      if (k % 3 == 0) irqReq = 1'b1;
      repeat (k % 6 + 1) cyc();
    end
    irqReq = 1'b1;
    repeat (40) cyc();
    // run-level checks
    vectors++;
    if (accepted < 3) begin
      miscompares++;
      $display("FAIL R7 accepted interrupts actual=%0d expected>=3", accepted);
    end
    vectors++;
    if (blockedSeen == 0) begin
      miscompares++;
      $display("FAIL R8 blocked request cycles actual=%0d expected>0", blockedSeen);
    end
    finished = 1;
    finishRun();
  end

endmodule